// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block puts one clause-22 management frame onto an MDC/MDIO pair toward an external PHY. Software prepares the whole frame as one 32-bit word and writes it into the frame register. That single write launches the transaction. The controller first sends a preamble of 32 ones. It then shifts out the frame word from its most significant bit down to bit 0, with one bit per MDC period.

When the opcode field selects a read, the controller releases MDIO from the turnaround onward. It samples the PHY's 16 data bits on rising MDC edges and puts the result back into the low half of the frame register. The end of each frame sets a sticky event bit, and software clears that bit by writing a 1 to it.

The MDC rate comes from a speed register. Its field holds the number of system clocks in each MDC half period, so ceil(f_sys / 5 MHz) gives an MDC of about 2.5 MHz. The host side is a plain register bus: a write strobe with address and data, and a read port that is combinational on the address.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Registers are selected by `bus_addr`: 0 is the frame register, 1 is the speed register, 2 is the event register. The speed field occupies bits DIV_W:1, and the completion event is bit 23 of the event register. All unused bits read 0. After reset every register reads 0, MDC is low and `mdio_oe` is low.
- R2: Writing the frame register while the speed field is non-zero and no frame is running starts a frame. The controller drives 32 ones and then frame bits 31 down to 0, one bit per MDC period. MDIO changes only after falling MDC edges, so each bit is stable across its rising edge.
- R3: While a frame runs, MDC is high for exactly S system clocks and low for exactly S clocks, where S is the speed field value latched when the frame started. Outside a frame, MDC stays low.
- R4: In a frame whose bits 29:28 are not 10 (for example 01, a write), `mdio_oe` stays high for all 64 bit periods.
- R5: In a frame whose bits 29:28 equal 10 (a read), `mdio_oe` goes low for the last 18 bit periods, which cover the turnaround and data. `mdio_i` is sampled on the rising MDC edges of the last 16 bit periods, first bit as bit 15. On completion those 16 bits replace frame register bits 15:0, and bits 31:16 keep their written value.
- R6: The event bit sets on the clock edge exactly 128·S system clocks after the edge that accepted the launching write.
- R7: Writing 1 to event bit 23 clears it. Writing 0 leaves it unchanged. If a completion lands in the same cycle as a clear, the bit is set.
- R8: While the speed field is 0, a frame register write is ignored. No frame starts, MDC stays low and the frame register keeps its old value.
- R9: A frame register write that arrives while a frame is running is ignored. The running frame continues unchanged and the register keeps the launched word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select for write and read |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on `bus_addr` |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable, high while the controller drives |
| mdio_i | input | 1 | MDIO value seen from the line |

## Verification
Register reads are due in the same cycle as the address, so the bench reads half a clock after it sets `bus_addr`. If a launching write lands on edge E, the first MDC rise comes on edge E+S, each following edge is S clocks later, and the event bit is due on edge E+128·S. The bench counts exactly 128·S−1 rising edges after E and samples on the falling clock to see the bit still clear, then one edge later to see it set. A model on the falling system clock records `mdio_o` and `mdio_oe` once per MDC high phase and measures every high phase in clocks. It also presents the next read-data bit at least one clock before the rising edge that samples it.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int REG_ADDR_W = 2;
  localparam int FRAME_W    = 32;
  localparam int PRE_LEN    = 32;
  localparam int FRAME_BITS = PRE_LEN + FRAME_W;
  localparam int DATA_W     = 16;
  localparam int TA_POS     = FRAME_BITS - DATA_W - 2;
  localparam int DATA_POS   = FRAME_BITS - DATA_W;
  localparam int OP_HI      = 29;
  localparam int OP_LO      = 28;
  localparam int EVENT_BIT  = 23;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_FRAME = 2'd0,
    REG_SPEED = 2'd1,
    REG_EVENT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_cnt,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             term;

  assign term = en && (cnt_q == half_cnt - 1'b1);
  assign rise = term && !mdc_q;
  assign fall = term && mdc_q;
  assign mdc  = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdi,
  output logic               busy,
  output logic               done,
  output logic               mdo,
  output logic               mdo_oe,
  output logic [DATA_W-1:0]  rd_word
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] PRE_END  = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

  logic               busy_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] sh_q;
  logic               rd_mode_q;
  logic [DATA_W-1:0]  cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      idx_q     <= '0;
      sh_q      <= '0;
      rd_mode_q <= 1'b0;
      cap_q     <= '0;
    end else if (start && !busy_q) begin
      busy_q    <= 1'b1;
      idx_q     <= '0;
      sh_q      <= frame_in;
      rd_mode_q <= (frame_in[OP_HI:OP_LO] == OP_READ);
      cap_q     <= '0;
    end else if (busy_q) begin
      if (rise && rd_mode_q && (idx_q >= DAT_IDX))
        cap_q <= {cap_q[DATA_W-2:0], mdi};
      if (fall) begin
        if (idx_q == LAST_IDX) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
        if (idx_q >= PRE_END)
          sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign busy    = busy_q;
  assign done    = busy_q && fall && (idx_q == LAST_IDX);
  assign mdo     = (!busy_q || (idx_q < PRE_END)) ? 1'b1 : sh_q[FRAME_W-1];
  assign mdo_oe  = busy_q && !(rd_mode_q && (idx_q >= TA_IDX));
  assign rd_word = cap_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  mdc,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  input  logic                  mdio_i
);
  logic [FRAME_W-1:0] frame_q;
  logic [DIV_W-1:0]   speed_q;
  logic [DIV_W-1:0]   div_q;
  logic               ev_q;
  logic               busy, done, rise, fall;
  logic [DATA_W-1:0]  rd_word;
  logic               wr_frame, wr_speed, wr_event, launch, is_read;

  assign wr_frame = bus_we && (bus_addr == REG_FRAME);
  assign wr_speed = bus_we && (bus_addr == REG_SPEED);
  assign wr_event = bus_we && (bus_addr == REG_EVENT);
  assign launch   = wr_frame && !busy && (speed_q != '0);
  assign is_read  = (frame_q[OP_HI:OP_LO] == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      speed_q <= '0;
      div_q   <= '0;
      ev_q    <= 1'b0;
    end else begin
      if (launch) begin
        frame_q <= bus_wdata;
        div_q   <= speed_q;
      end else if (done && is_read) begin
        frame_q[DATA_W-1:0] <= rd_word;
      end
      if (wr_speed) speed_q <= bus_wdata[DIV_W:1];
      if (done)                              ev_q <= 1'b1;
      else if (wr_event && bus_wdata[EVENT_BIT]) ev_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_FRAME: bus_rdata = frame_q;
      REG_SPEED: bus_rdata[DIV_W:1] = speed_q;
      REG_EVENT: bus_rdata[EVENT_BIT] = ev_q;
      default:   bus_rdata = '0;
    endcase
  end

  mdc_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (busy),
    .half_cnt (div_q),
    .mdc      (mdc),
    .rise     (rise),
    .fall     (fall)
  );

  mdio_frame_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch),
    .frame_in (bus_wdata),
    .rise     (rise),
    .fall     (fall),
    .mdi      (mdio_i),
    .busy     (busy),
    .done     (done),
    .mdo      (mdio_o),
    .mdo_oe   (mdio_oe),
    .rd_word  (rd_word)
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  done,
  input logic                  mdc,
  input logic                  mdio_oe,
  input logic                  is_read,
  input logic                  wr_frame,
  input logic [DIV_W-1:0]      speed_q,
  input logic [FRAME_W-1:0]    frame_q,
  input logic                  ev_q,
  input logic                  bus_we,
  input logic [REG_ADDR_W-1:0] bus_addr,
  input logic [31:0]           bus_wdata
);
  // R3: MDC rests low outside a frame
  a_r3_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R4: a non-read frame keeps the line driven
  a_r4_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_read) |-> mdio_oe);

  // R6: end of a frame leaves the event bit set
  a_r6_event_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ev_q);

  // R7: clearing write without a coincident completion clears the bit
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == REG_EVENT && bus_wdata[EVENT_BIT] && !done) |=> !ev_q);

  // R8: zero speed blocks a launch
  a_r8_zero_speed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_frame && !busy && speed_q == '0) |=> !busy);

  // R9: frame register frozen while a frame runs
  a_r9_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(frame_q));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .mdc       (mdc),
  .mdio_oe   (mdio_oe),
  .is_read   (is_read),
  .wr_frame  (wr_frame),
  .speed_q   (speed_q),
  .frame_q   (frame_q),
  .ev_q      (ev_q),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] mon_bits, mon_oe;
  int          mon_n = 0;
  logic        mdc_prev = 1'b0;
  int          hi_run = 0;
  int          hi_bad = 0;
  int          s_exp = 1;
  logic [15:0] phy_val = 16'h0;

  always #10 clk = ~clk;

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY-side model: record one bit per MDC high phase, drive read data
  always @(negedge clk) begin
    if (mdc && !mdc_prev && mon_n < 64) begin
      mon_bits[63-mon_n] = mdio_o;
      mon_oe[63-mon_n]   = mdio_oe;
      mon_n++;
    end
    if (mdc) hi_run++;
    else begin
      if (mdc_prev && hi_run != s_exp) hi_bad++;
      hi_run = 0;
    end
    mdc_prev = mdc;
    mdio_i = (mon_n >= 48 && mon_n < 64) ? phy_val[63-mon_n] : 1'b1;
  end

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 2'd2;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // launch a frame and check R6 timing of the event bit
  task automatic run_frame(input int s, input logic [31:0] fr);
    logic [31:0] d;
    bus_write(2'd2, 32'h0080_0000);
    bus_write(2'd1, 32'(s) << 1);
    s_exp = s; hi_bad = 0; mon_n = 0;
    bus_write(2'd0, fr);
    repeat (128*s - 1) @(posedge clk);
    @(negedge clk); #1 d = bus_rdata;
    chk64("R6 event not yet", {63'd0, d[23]}, 64'd0);
    @(posedge clk); @(negedge clk); #1 d = bus_rdata;
    chk64("R6 event due", {63'd0, d[23]}, 64'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(2'd0, d); chk64("R1 frame reset", {32'd0, d}, 64'd0);
    bus_read(2'd1, d); chk64("R1 speed reset", {32'd0, d}, 64'd0);
    bus_read(2'd2, d); chk64("R1 event reset", {32'd0, d}, 64'd0);
    chk64("R1 mdc/oe idle", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  task automatic t_speed_reg();
    logic [31:0] d;
    bus_write(2'd1, 32'd5 << 1);
    bus_read(2'd1, d); chk64("R1 speed readback", {32'd0, d}, 64'h0A);
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, d); chk64("R1 speed field bits", {32'd0, d}, 64'h7E);
    bus_read(2'd3, d); chk64("R1 unused address", {32'd0, d}, 64'd0);
  endtask

  task automatic t_zero_speed();
    logic [31:0] d;
    bus_write(2'd1, 32'd0);
    mon_n = 0;
    bus_write(2'd0, 32'h5123_4567);
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk64("R8 no mdc activity", 64'(mon_n), 64'd0);
    bus_read(2'd0, d); chk64("R8 frame unchanged", {32'd0, d}, 64'd0);
    bus_read(2'd2, d); chk64("R8 no event", {32'd0, d}, 64'd0);
  endtask

  task automatic t_write_frame();
    logic [31:0] d;
    run_frame(2, 32'h5196_A5C3);
    chk64("R2 serial bits", mon_bits, {32'hFFFF_FFFF, 32'h5196_A5C3});
    chk64("R4 oe all bits", mon_oe, {64{1'b1}});
    chk64("R3 high phase S=2", 64'(hi_bad), 64'd0);
    chk64("R3 mdc low after", {63'd0, mdc}, 64'd0);
    bus_read(2'd0, d); chk64("R2 frame kept", {32'd0, d}, {32'd0, 32'h5196_A5C3});
  endtask

  task automatic t_read_frame();
    logic [31:0] d;
    phy_val = 16'hBEEF;
    run_frame(3, 32'h6086_1234);
    chk64("R5 header bits", {18'd0, mon_bits[63:18]}, {18'd0, 32'hFFFF_FFFF, 14'(32'h6086_1234 >> 18)});
    chk64("R5 oe release", mon_oe, 64'hFFFF_FFFF_FFFC_0000);
    chk64("R3 high phase S=3", 64'(hi_bad), 64'd0);
    bus_read(2'd0, d); chk64("R5 read data", {32'd0, d}, {32'd0, 32'h6086_BEEF});
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    bus_write(2'd2, 32'hFF7F_FFFF);
    bus_read(2'd2, d); chk64("R7 write 0 keeps", {32'd0, d}, 64'h0080_0000);
    bus_write(2'd2, 32'h0080_0000);
    bus_read(2'd2, d); chk64("R7 write 1 clears", {32'd0, d}, 64'd0);
  endtask

  task automatic t_busy_write();
    logic [31:0] d;
    bus_write(2'd2, 32'h0080_0000);
    bus_write(2'd1, 32'd1 << 1);
    s_exp = 1; hi_bad = 0; mon_n = 0;
    bus_write(2'd0, 32'h5082_3C3C);
    repeat (20) @(posedge clk);
    bus_write(2'd0, 32'h6FFF_FFFF);
    bus_read(2'd0, d); chk64("R9 frame held mid-run", {32'd0, d}, {32'd0, 32'h5082_3C3C});
    repeat (140) @(posedge clk);
    @(negedge clk);
    chk64("R9 bits unchanged", mon_bits, {32'hFFFF_FFFF, 32'h5082_3C3C});
    chk64("R3 high phase S=1", 64'(hi_bad), 64'd0);
    bus_read(2'd0, d); chk64("R9 frame after", {32'd0, d}, {32'd0, 32'h5082_3C3C});
    bus_read(2'd2, d); chk64("R6 event after busy test", {32'd0, d}, 64'h0080_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_speed_reg();
    t_zero_speed();
    t_write_frame();
    t_read_frame();
    t_w1c();
    t_busy_write();
    summary();
  end
endmodule